// File: doc/BRIEF.md
# Weighted Score Summer with Cascade

This block turns eight per-stage match counts into a single correlation score. Each stage count is 6 bits wide. It is scaled by a power of two that depends on the data width being correlated. A 13-bit programmable offset is then added. The result travels through a delay line whose length can be set from 1 to 16 clocks. At the end of the line it is added to a 13-bit cascade input taken from an upstream device. Chained devices set increasing delays so that all their partial scores arrive at the last adder together.

A dual setting splits the eight stages into two independent correlators of four stages each. The upper group (stages 7..4) uses the 13-bit offset A. Its 9-bit result appears on the low bits of the cascade output. The lower group (stages 3..0) uses a 9-bit offset B, and its result appears on an auxiliary output. In dual mode the cascade input and the delay code are ignored, and both results come out one clock after their inputs. The configuration inputs are sampled into registers, so a change of mode or delay code applies from the next clock. The delay line is not cleared when this happens.

Top module: `weighted_score_summer`

## Requirements
- R1: With width code 0 (1-bit data), every stage count has weight 1.
- R2: With width code 1 (2-bit data) in single mode, stages 7..4 weigh 2 and stages 3..0 weigh 1.
- R3: With width code 2 (4-bit data) in single mode, the weights are 8 for stages 7 and 6, 4 for stages 5 and 4, 2 for stages 3 and 2, and 1 for stages 1 and 0.
- R4: With width code 3 (8-bit data) in single mode, stage k weighs 2^k.
- R5: In single mode, cas_out equals the delayed (weighted sum + offset_a) plus the current cas_in. The cas_in term is not delayed, so a cas_in change shows on cas_out in the same cycle.
- R6: In single mode, delay code d makes a score change at the input appear on cas_out exactly d+1 clocks later (code 0 gives 1 clock, code 15 gives 16 clocks).
- R7: In dual mode, cas_out[8:0] carries (weighted stages 7..4 + offset_a) mod 512, cas_out[12:9] is zero, and cas_in has no effect. Within the group, the weights are 1,1,1,1 for width code 0, 2,2,1,1 for code 1, and 8,4,2,1 for codes 2 and 3 (listed from the highest stage down).
- R8: In dual mode, aux_out carries (weighted stages 3..0 + offset_b) mod 512, with the same in-group weights as R7. In single mode aux_out is zero.
- R9: In dual mode the delay code is ignored, and both results appear one clock after their inputs.
- R10: While reset is held, the delay line and the auxiliary register are cleared, so cas_out equals cas_in and aux_out is zero.
- R11: All sums wrap modulo 2^13 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stage_scores | input | 48 | Stage k count in bits [6k+5:6k] |
| width_code | input | 2 | Data width: 0=1-bit, 1=2-bit, 2=4-bit, 3=8-bit |
| dual_mode | input | 1 | 1 selects two independent correlators |
| delay_code | input | 4 | Delay line length minus one |
| offset_a | input | 13 | Offset for single mode or correlator A |
| offset_b | input | 9 | Offset for correlator B |
| cas_in | input | 13 | Cascade score from upstream |
| cas_out | output | 13 | Cascade score, or correlator A in dual mode |
| aux_out | output | 9 | Correlator B score in dual mode, else zero |

## Verification
The delayed local score and a change of the cascade input can land on the cascade adder in the same cycle. The bench provokes this with a delay code of 5: it drives a single-count pulse, then alters cas_in during the clock just before the pulse emerges. It first checks that the new cas_in alone appears at once. It then checks that, after the next edge, the output is the sum of both. A second case drives a nonzero delay code in dual mode and judges that both correlators still answer after one clock.

// File: rtl/wss_pkg.sv
package wss_pkg;

  typedef enum logic [1:0] {
    DW_1 = 2'd0,
    DW_2 = 2'd1,
    DW_4 = 2'd2,
    DW_8 = 2'd3
  } dwidth_e;

  // Left-shift amount (log2 of weight) for stage k.
  function automatic int unsigned stage_shift(input dwidth_e w, input logic dual,
                                              input int unsigned k);
    int unsigned j;
    j = dual ? (k % 4) : k;
    case (w)
      DW_1:    return 0;
      DW_2:    return dual ? ((j >= 2) ? 1 : 0) : ((k >= 4) ? 1 : 0);
      DW_4:    return dual ? j : (k / 2);
      default: return j;
    endcase
  endfunction

endpackage

// File: rtl/wss_weigher.sv
module wss_weigher
  import wss_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int SCORE_W  = 6,
  parameter int SUM_W    = 13,
  parameter int AUX_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_STAGES*SCORE_W-1:0] scores,
  input  dwidth_e                     width,
  input  logic                        dual,
  input  logic [SUM_W-1:0]            off_a,
  input  logic [AUX_W-1:0]            off_b,
  output logic [SUM_W-1:0]            sum_a,
  output logic [AUX_W-1:0]            sum_b
);
  localparam int HALF = N_STAGES / 2;

  logic [SUM_W-1:0] term [N_STAGES];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_term
    assign term[g] = SUM_W'(scores[g*SCORE_W +: SCORE_W]) << stage_shift(width, dual, g);
  end

  always_comb begin
    logic [SUM_W-1:0] acc_a;
    logic [AUX_W-1:0] acc_b;
    acc_a = off_a;
    acc_b = off_b;
    for (int k = 0; k < N_STAGES; k++) begin
      if (dual && (k < HALF)) acc_b = acc_b + term[k][AUX_W-1:0];
      else                    acc_a = acc_a + term[k];
    end
    sum_a = acc_a;
    sum_b = acc_b;
  end

  AST_ZERO_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
    (scores == '0 && !dual) |-> (sum_a == off_a)); // R5

endmodule

// File: rtl/wss_delay_line.sv
module wss_delay_line #(
  parameter int W     = 13,
  parameter int DEPTH = 16,
  localparam int SELW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    din,
  input  logic [SELW-1:0] sel,
  output logic [W-1:0]    dout
);
  logic [W-1:0] taps [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) taps[g] <= '0;
        else        taps[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) taps[g] <= '0;
        else        taps[g] <= taps[g-1];
      end
    end
  end

  assign dout = taps[sel];

  AST_TAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sel == '0) |-> (dout == $past(din))); // R6

endmodule

// File: rtl/weighted_score_summer.sv
module weighted_score_summer
  import wss_pkg::*;
#(
  parameter int N_STAGES  = 8,
  parameter int SCORE_W   = 6,
  parameter int SUM_W     = 13,
  parameter int AUX_W     = 9,
  parameter int DELAY_MAX = 16,
  localparam int CODE_W   = $clog2(DELAY_MAX),
  localparam int IN_W     = N_STAGES * SCORE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   stage_scores,
  input  logic [1:0]        width_code,
  input  logic              dual_mode,
  input  logic [CODE_W-1:0] delay_code,
  input  logic [SUM_W-1:0]  offset_a,
  input  logic [AUX_W-1:0]  offset_b,
  input  logic [SUM_W-1:0]  cas_in,
  output logic [SUM_W-1:0]  cas_out,
  output logic [AUX_W-1:0]  aux_out
);
  logic [SUM_W-1:0]  sum_a;
  logic [AUX_W-1:0]  sum_b;
  logic [SUM_W-1:0]  line_out;
  logic [CODE_W-1:0] sel_q;
  logic [CODE_W-1:0] eff_sel;
  logic              dual_q;
  logic [AUX_W-1:0]  b_q;

  wss_weigher #(
    .N_STAGES(N_STAGES), .SCORE_W(SCORE_W), .SUM_W(SUM_W), .AUX_W(AUX_W)
  ) u_weigh (
    .clk(clk), .rst_n(rst_n), .scores(stage_scores),
    .width(dwidth_e'(width_code)), .dual(dual_mode),
    .off_a(offset_a), .off_b(offset_b), .sum_a(sum_a), .sum_b(sum_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dual_q <= 1'b0;
      b_q    <= '0;
    end else begin
      sel_q  <= delay_code;
      dual_q <= dual_mode;
      b_q    <= sum_b;
    end
  end

  assign eff_sel = dual_q ? '0 : sel_q;

  wss_delay_line #(.W(SUM_W), .DEPTH(DELAY_MAX)) u_line (
    .clk(clk), .rst_n(rst_n), .din(sum_a), .sel(eff_sel), .dout(line_out)
  );

  assign cas_out = dual_q ? SUM_W'(line_out[AUX_W-1:0]) : (line_out + cas_in);
  assign aux_out = dual_q ? b_q : '0;

  AST_SINGLE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !dual_q && sel_q == '0) |-> (cas_out == $past(sum_a) + cas_in)); // R5
  AST_DUAL_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dual_q) |-> (cas_out == SUM_W'($past(sum_a[AUX_W-1:0])))); // R7
  AST_DUAL_B: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dual_q) |-> (aux_out == $past(sum_b))); // R8

endmodule

// File: tb/weighted_score_summer_test.sv
module weighted_score_summer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] stage_scores = '0;
  logic [1:0]  width_code = '0;
  logic        dual_mode = 1'b0;
  logic [3:0]  delay_code = '0;
  logic [12:0] offset_a = '0;
  logic [8:0]  offset_b = '0;
  logic [12:0] cas_in = '0;
  logic [12:0] cas_out;
  logic [8:0]  aux_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  weighted_score_summer uut (
    .clk(clk), .rst_n(rst_n), .stage_scores(stage_scores), .width_code(width_code),
    .dual_mode(dual_mode), .delay_code(delay_code), .offset_a(offset_a),
    .offset_b(offset_b), .cas_in(cas_in), .cas_out(cas_out), .aux_out(aux_out)
  );

  typedef struct packed {
    logic [1:0]  w;
    logic        d;
    logic [47:0] sc;
    logic [12:0] oa;
    logic [8:0]  ob;
    logic [12:0] ci;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, {8{6'd63}}, 13'd0, 9'd0, 13'd0, 8'd1},                                       // R1
    '{2'd1, 1'b0, {6'd8,6'd7,6'd6,6'd5,6'd4,6'd3,6'd2,6'd1}, 13'd100, 9'd0, 13'd5, 8'd2},      // R2
    '{2'd2, 1'b0, {8{6'd63}}, 13'd0, 9'd0, 13'd0, 8'd3},                                       // R3
    '{2'd3, 1'b0, {6'd1,6'd2,6'd3,6'd4,6'd5,6'd6,6'd7,6'd8}, 13'd1000, 9'd0, 13'd3, 8'd4},     // R4
    '{2'd3, 1'b0, {8{6'd63}}, 13'd0, 9'd0, 13'd8191, 8'd11},                                   // R11
    '{2'd3, 1'b1, {8{6'd63}}, 13'd8191, 9'd511, 13'd1234, 8'd7},                               // R7
    '{2'd1, 1'b1, {6'd10,6'd20,6'd30,6'd40,6'd1,6'd2,6'd3,6'd4}, 13'd7, 9'd9, 13'd77, 8'd8},   // R8
    '{2'd0, 1'b1, {6'd5,6'd6,6'd7,6'd8,6'd9,6'd10,6'd11,6'd12}, 13'd300, 9'd500, 13'd1, 8'd8}, // R8
    '{2'd2, 1'b1, {6'd63,6'd1,6'd2,6'd3,6'd33,6'd0,6'd1,6'd63}, 13'd2, 9'd4, 13'd9, 8'd7}      // R7
  };

  // Weight restated from R1..R4 and R7 as plain multipliers.
  function automatic int weight_of(input int w, input bit d, input int k);
    int j;
    if (!d) begin
      case (w)
        0: return 1;
        1: return (k > 3) ? 2 : 1;
        2: return (k > 5) ? 8 : (k > 3) ? 4 : (k > 1) ? 2 : 1;
        default: return 2 ** k;
      endcase
    end
    j = k - ((k > 3) ? 4 : 0);
    case (w)
      0: return 1;
      1: return (j > 1) ? 2 : 1;
      default: return 2 ** j;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_zero(input bit d, input int code);
    @(negedge clk);
    stage_scores = '0; width_code = 2'd0; dual_mode = d; delay_code = 4'(code);
    offset_a = '0; offset_b = '0; cas_in = '0;
    repeat (20) @(negedge clk);
  endtask

  task automatic delay_probe(input int d);
    idle_zero(1'b0, d);
    stage_scores = 48'd1;
    if (d > 0) repeat (d) @(negedge clk);
    #1 chk($sformatf("R6 code %0d before", d), cas_out, 0);
    if (d == 5) begin
      cas_in = 13'd100;
      #1 chk("R5 cas_in same cycle", cas_out, 100);
    end
    @(negedge clk);
    #1 chk($sformatf("R6 code %0d arrival", d), cas_out, 1 + cas_in);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 cas_out in reset", cas_out, 0);
    chk("R10 aux_out in reset", aux_out, 0);
    cas_in = 13'd42;
    #1 chk("R10 cas_out follows cas_in in reset", cas_out, 42);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table walk, delay code 0, inputs held steady
    for (int v = 0; v < NV; v++) begin
      int sa, sb, ecas, eaux;
      @(negedge clk);
      width_code = VECS[v].w; dual_mode = VECS[v].d; delay_code = 4'd0;
      stage_scores = VECS[v].sc; offset_a = VECS[v].oa; offset_b = VECS[v].ob;
      cas_in = VECS[v].ci;
      sa = VECS[v].oa; sb = VECS[v].ob;
      for (int k = 0; k < 8; k++) begin
        int s;
        s = int'(VECS[v].sc[k*6 +: 6]) * weight_of(int'(VECS[v].w), VECS[v].d, k);
        if (VECS[v].d && k < 4) sb += s;
        else                    sa += s;
      end
      if (VECS[v].d) begin
        ecas = sa % 512;
        eaux = sb % 512;
      end else begin
        ecas = (sa + int'(VECS[v].ci)) % 8192;
        eaux = 0;
      end
      repeat (3) @(negedge clk);
      chk($sformatf("vec %0d R%0d cas_out", v, VECS[v].req), cas_out, ecas);
      chk($sformatf("vec %0d R%0d aux_out", v, VECS[v].req), aux_out, eaux);
    end

    // R6: delay lengths 1, 6 and 16 clocks
    delay_probe(0);
    delay_probe(5);
    delay_probe(15);

    // R9: dual mode ignores a nonzero delay code
    idle_zero(1'b1, 9);
    stage_scores = {6'd0, 6'd0, 6'd0, 6'd1, 6'd0, 6'd0, 6'd0, 6'd2};
    #1 chk("R9 dual before edge", cas_out, 0);
    @(negedge clk);
    #1 chk("R9 dual A after one clock", cas_out, 1);
    chk("R9 dual B after one clock", aux_out, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule